// File: doc/BRIEF.md
# Grouped Interrupt Event Queue Controller

This block gathers interrupt events from three source groups: communications, I/O and timed. Each event is a one-cycle pulse that carries an event number. Every group keeps its own first-in-first-out queue. The block hands exactly one event at a time to a single service handler. The handler keeps the event until it strobes done. No event can preempt a running handler, whatever group the event comes from.

Events are always queued, whether or not the global enable is set. The enable only gates dispatch, so timed events that arrive while dispatch is off are held until their queue fills. When an event meets a full queue, the event is lost and a sticky lost-event flag for that group is raised. The flags stay set while the handler runs, so the handler can read them. They clear on the done strobe that finds every queue empty, which is the point where control returns to the main program.

Queue depths are parameters. The default depths are 4 for communications, 16 for I/O and 8 for timed.

Top module: `irq_queue_ctrl`

## Requirements
- R1: After reset, `disp_valid_o` is 0 and `ovf_o` is 3'b000.
- R2: Within one group, events are dispatched in the order they arrived.
- R3: When more than one queue holds events at the moment of dispatch, the communications queue wins over I/O, and I/O wins over timed.
- R4: A dispatch takes place only when `irq_en_i` is 1, no handler is active and at least one queue is non-empty. The event appears on `disp_num_o` together with `disp_grp_o` (0 = communications, 1 = I/O, 2 = timed) and `disp_valid_o` = 1, two clock edges after the event pulse when the block is idle and enabled.
- R5: While `disp_valid_o` is 1 and `done_i` is 0, the dispatched number and group hold steady. A newly arrived event of any priority does not replace them.
- R6: `done_i` while active drops `disp_valid_o` on the next edge. The next dispatch can appear no earlier than the edge after that.
- R7: Events that arrive while `irq_en_i` is 0 are queued and are dispatched once the enable returns.
- R8: An event that arrives at a full queue, with no dequeue from that queue in the same cycle, is dropped. It sets that group's bit of `ovf_o` (bit 0 = communications, bit 1 = I/O, bit 2 = timed). The events already queued are unaffected.
- R9: An `ovf_o` bit stays set until a `done_i` that finds all three queues empty. That done clears all bits.
- R10: An enqueue and a dequeue on the same queue in the same cycle are both honoured, even when the queue is full. No event is lost and no overflow bit is set.
- R11: The queue depths are set by the parameters `COMM_DEPTH`, `IO_DEPTH` and `TMR_DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 3 | Event pulse per group (bit 0 comm, 1 I/O, 2 timed) |
| evt_num_i | input | 3 x EVW | Event number per group |
| irq_en_i | input | 1 | Global dispatch enable |
| done_i | input | 1 | Handler completion strobe |
| disp_valid_o | output | 1 | A handler is active with the shown event |
| disp_num_o | output | EVW | Dispatched event number |
| disp_grp_o | output | 2 | Group of the dispatched event |
| ovf_o | output | 3 | Sticky lost-event flag per group |

## Verification
The bench fills queues while dispatch is disabled, then releases them. A design that ignored priority would mix the groups, and one that served a queue as a stack would reverse its events. Higher-priority events are injected in the middle of a handler, which a preemptive design would let through, and the enable is dropped while a handler runs, which a design that latched the enable would ignore. The bench also overflows two queues and checks that the flags survive until the final done. Finally it pushes into a full queue in the very cycle that queue is dequeued: a design that checks fullness alone would lose that event and set its overflow flag.

// File: rtl/irq_q_pkg.sv
package irq_q_pkg;
  localparam int NGRP = 3;
  localparam int GW   = 2;
  typedef enum logic [GW-1:0] {
    GRP_COMM = 2'd0,
    GRP_IO   = 2'd1,
    GRP_TMR  = 2'd2
  } grp_e;
endpackage

// File: rtl/irq_fifo.sv
module irq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         nempty_o,
  output logic         drop_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          full, accept, take;

  assign full     = (cnt == CW'(DEPTH));
  assign nempty_o = (cnt != '0);
  // a push into a full queue survives when the same cycle frees a slot
  assign accept   = push_i && (!full || pop_i);
  assign take     = pop_i && nempty_o;
  assign drop_o   = push_i && !accept;
  assign data_o   = mem[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (accept) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (accept) wr_ptr <= nxt(wr_ptr);
      if (take)   rd_ptr <= nxt(rd_ptr);
      case ({accept, take})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irq_queue_ctrl.sv
module irq_queue_ctrl
  import irq_q_pkg::*;
#(
  parameter int EVW        = 8,
  parameter int COMM_DEPTH = 4,
  parameter int IO_DEPTH   = 16,
  parameter int TMR_DEPTH  = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NGRP-1:0]           evt_i,
  input  logic [NGRP-1:0][EVW-1:0]  evt_num_i,
  input  logic                      irq_en_i,
  input  logic                      done_i,
  output logic                      disp_valid_o,
  output logic [EVW-1:0]            disp_num_o,
  output logic [GW-1:0]             disp_grp_o,
  output logic [NGRP-1:0]           ovf_o
);
  logic [EVW-1:0]  head [NGRP];
  logic [NGRP-1:0] q_nempty, q_drop;
  logic [GW-1:0]   pick_idx;
  logic            pick_any, launch, drained;
  logic [EVW-1:0]  head_sel;

  logic            active_q;
  logic [EVW-1:0]  num_q;
  grp_e            grp_q;
  logic [NGRP-1:0] ovf_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_q
    localparam int D = (g == 0) ? COMM_DEPTH : ((g == 1) ? IO_DEPTH : TMR_DEPTH);
    irq_fifo #(.DEPTH(D), .W(EVW)) u_fifo (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .push_i   (evt_i[g]),
      .data_i   (evt_num_i[g]),
      .pop_i    (launch && (pick_idx == GW'(g))),
      .data_o   (head[g]),
      .nempty_o (q_nempty[g]),
      .drop_o   (q_drop[g])
    );
  end

  irq_pick #(.N(NGRP), .IW(GW)) u_pick (
    .req_i (q_nempty),
    .idx_o (pick_idx),
    .any_o (pick_any)
  );

  always_comb begin
    head_sel = '0;
    for (int i = 0; i < NGRP; i++) begin
      if (pick_idx == GW'(i)) head_sel = head[i];
    end
  end

  assign launch  = irq_en_i && !active_q && pick_any;
  // return to main program: handler finishes with nothing left queued
  assign drained = active_q && done_i && !pick_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      num_q    <= '0;
      grp_q    <= GRP_COMM;
      ovf_q    <= '0;
    end else begin
      if (launch) begin
        active_q <= 1'b1;
        num_q    <= head_sel;
        grp_q    <= grp_e'(pick_idx);
      end else if (active_q && done_i) begin
        active_q <= 1'b0;
      end
      ovf_q <= (drained ? '0 : ovf_q) | q_drop;
    end
  end

  assign disp_valid_o = active_q;
  assign disp_num_o   = num_q;
  assign disp_grp_o   = grp_q;
  assign ovf_o        = ovf_q;
endmodule

// File: rtl/irq_queue_ctrl_chk.sv
module irq_queue_ctrl_chk
  import irq_q_pkg::*;
#(
  parameter int EVW = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            irq_en_i,
  input logic            done_i,
  input logic            disp_valid_o,
  input logic [EVW-1:0]  disp_num_o,
  input logic [GW-1:0]   disp_grp_o,
  input logic [NGRP-1:0] ovf_o,
  input logic [NGRP-1:0] q_nempty,
  input logic [NGRP-1:0] q_drop
);
  // R5
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o && !done_i |=> disp_valid_o && $stable(disp_num_o) && $stable(disp_grp_o));

  // R6
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o && done_i |=> !disp_valid_o);

  // R4
  launch_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(disp_valid_o) |-> $past(irq_en_i));

  // R4
  idle_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_valid_o && irq_en_i && (q_nempty != '0) |=> disp_valid_o);

  // R3
  prio_io_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(disp_valid_o) && (disp_grp_o == GRP_IO) |-> !$past(q_nempty[0]));

  // R3
  prio_tmr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(disp_valid_o) && (disp_grp_o == GRP_TMR) |-> ($past(q_nempty[1:0]) == 2'b00));

  // R8
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(ovf_o & ~$past(ovf_o)) |-> $past(|q_drop));

  // R9
  ovf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |($past(ovf_o) & ~ovf_o) |-> $past(done_i && disp_valid_o && (q_nempty == '0)));
endmodule

bind irq_queue_ctrl irq_queue_ctrl_chk #(.EVW(EVW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_en_i     (irq_en_i),
  .done_i       (done_i),
  .disp_valid_o (disp_valid_o),
  .disp_num_o   (disp_num_o),
  .disp_grp_o   (disp_grp_o),
  .ovf_o        (ovf_o),
  .q_nempty     (q_nempty),
  .q_drop       (q_drop)
);

// File: tb/tb_irq_queue_ctrl.sv
`timescale 1ns/1ps
module tb_irq_queue_ctrl;
  localparam int EVW  = 8;
  localparam int HOLD = 6;

  logic              clk, rst_n;
  logic [2:0]        evt;
  logic [2:0][EVW-1:0] num;
  logic              en, done;
  logic              disp_valid;
  logic [EVW-1:0]    disp_num;
  logic [1:0]        disp_grp;
  logic [2:0]        ovf;

  irq_queue_ctrl #(.EVW(EVW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .evt_num_i(num),
    .irq_en_i(en), .done_i(done), .disp_valid_o(disp_valid),
    .disp_num_o(disp_num), .disp_grp_o(disp_grp), .ovf_o(ovf)
  );

  int errors = 0, checks = 0;
  logic [EVW-1:0] mq [3][$];
  int dep [3] = '{4, 16, 8};
  logic [2:0] exp_ovf = '0;
  logic [EVW-1:0] next_id = 8'd1;
  logic busy = 1'b0;
  int n_disp = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one event pulse, expected item pushed into the group model
  task automatic fire(input int g);
    @(negedge clk);
    evt[g] = 1'b1;
    num[g] = next_id;
    if (mq[g].size() >= dep[g]) exp_ovf[g] = 1'b1;
    else mq[g].push_back(next_id);
    next_id++;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (mq[0].size() + mq[1].size() + mq[2].size() == 0 && !busy && !disp_valid) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // monitor / handler
  initial begin
    done = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && disp_valid) begin
        int g;
        logic [EVW-1:0] e;
        busy = 1'b1;
        n_disp++;
        g = -1;
        for (int k = 2; k >= 0; k--) if (mq[k].size() != 0) g = k;
        if (g < 0) begin
          chk("R4 unexpected dispatch", 1'b0, disp_num, 0);
          e = disp_num;
        end else begin
          e = mq[g].pop_front();
          chk("R2 R3 number", disp_num == e, disp_num, e);
          chk("R3 R4 group", disp_grp == 2'(g), disp_grp, g);
        end
        for (int h = 0; h < HOLD; h++) begin
          @(negedge clk);
          chk("R5 held", disp_valid && disp_num == e, disp_num, e);
        end
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        if (mq[0].size() + mq[1].size() + mq[2].size() == 0) exp_ovf = '0;
        chk("R6 release", !disp_valid, disp_valid, 0);
        chk("R9 ovf after done", ovf == exp_ovf, ovf, exp_ovf);
        busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt = '0; num = '0; en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid", !disp_valid, disp_valid, 0);
    chk("R1 ovf", ovf == 3'b000, ovf, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", !disp_valid, disp_valid, 0);

    // R7 R3 R2: queue mixed groups while disabled, then release
    fire(2); fire(1); fire(2); fire(0); fire(1); fire(2); fire(0);
    repeat (5) @(negedge clk);
    chk("R7 no dispatch while disabled", !disp_valid, disp_valid, 0);
    en = 1'b1;
    drain();
    chk("R7 all dispatched", n_disp == 7, n_disp, 7);

    // R4 latency and R5 no preemption
    @(negedge clk);
    evt[1] = 1'b1; num[1] = next_id; mq[1].push_back(next_id); next_id++;
    @(negedge clk);
    evt = '0;
    chk("R4 not yet", !disp_valid, disp_valid, 0);
    @(negedge clk);
    chk("R4 two edges", disp_valid, disp_valid, 1);
    fire(2); fire(0);
    drain();

    // R8 R9 overflow two queues
    en = 1'b0;
    for (int i = 0; i < 5; i++) fire(0);
    for (int i = 0; i < 9; i++) fire(2);
    @(negedge clk);
    chk("R8 ovf bits", ovf == 3'b101, ovf, 3'b101);
    chk("R8 exp ovf", exp_ovf == 3'b101, exp_ovf, 3'b101);
    en = 1'b1;
    drain();
    chk("R9 ovf cleared", ovf == 3'b000, ovf, 0);

    // R10 push into full queue on the dequeue cycle
    en = 1'b0;
    for (int i = 0; i < 4; i++) fire(0);
    @(negedge clk);
    en = 1'b1;
    evt[0] = 1'b1; num[0] = next_id; mq[0].push_back(next_id); next_id++;
    @(negedge clk);
    evt = '0;
    chk("R10 no ovf", ovf == 3'b000, ovf, 0);
    drain();
    chk("R10 no loss", ovf == 3'b000 && mq[0].size() == 0, ovf, 0);

    // R4 enable dropped during a handler
    fire(1); fire(1); fire(1);
    while (!busy) @(negedge clk);
    en = 1'b0;
    while (busy) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R4 held off when disabled", !disp_valid, disp_valid, 0);
    end
    en = 1'b1;
    drain();
    chk("R11 deep io queue drained", mq[1].size() == 0, mq[1].size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule